// File: doc/BRIEF.md
# Indirect switch-register access sequencer over MDIO

The block lets a host reach a 16-bit internal register space that sits behind a handful of MDIO registers. The host makes one request: a read or a write, a 16-bit internal address and, for a write, 16 bits of data. The block then runs a fixed script of MDIO management frames through a downstream frame engine. It passes that engine one command at a time and waits for the engine's done before it issues the next command. When the last frame has completed, the block pulses its response and, for a read, presents the 16-bit value that the final frame returned.

The script is chosen at build time. In the full script, every functional step is preceded by a start command to register 29, so a request takes eight frames. The compact script uses four frames, built on a control register (13) and a data port (14). The block holds every command field stable until the engine reports completion. It accepts no new request while a script is running, so a script is never interleaved with another request.

Top module: `mdio_ind_seq`

## Requirements
- R1: After reset, req_ready_o is 1 and cmd_valid_o and rsp_done_o are 0.
- R2: A request is accepted on a rising edge where req_valid_i and req_ready_o are both 1. From the next cycle until the script ends, req_ready_o is 0 and req_valid_i has no effect on the frames issued.
- R3: Full-mode write, eight frames, all with cmd_write_o=1, as (register, data): (29,START_OP), (31,ADDR_OP), (29,START_OP), (23,address), (29,START_OP), (24,wdata), (29,START_OP), (21,WR_OP).
- R4: Full-mode read, eight frames: (29,START_OP), (31,ADDR_OP), (29,START_OP), (23,address), (29,START_OP), (21,RD_OP), (29,START_OP), then a read frame (cmd_write_o=0, data 0) of register 25.
- R5: In full mode, every even-numbered frame (counting from 0) is a start command: a write of START_OP to register 29.
- R6: Every frame carries cmd_phy_o = PHY_ID and cmd_pre_o = PRE_LEN.
- R7: Only one command is outstanding at a time. While cmd_valid_o is 1 and cmd_done_i has not been seen, the write flag, the register and the data hold their values. A new command appears only after a done.
- R8: rsp_done_o is a one-cycle pulse in the cycle after the final frame's cmd_done_i. For a read, rsp_rdata_o then equals the cmd_rdata_i sampled with that done.
- R9: Compact-mode write, four frames, all writes: (13,ADDR_OP), (14,address), (13,DATA_OP), (14,wdata).
- R10: Compact-mode read: (13,ADDR_OP), (14,address), (13,DATA_OP), then a read frame of register 14 whose returned value becomes rsp_rdata_o.
- R11: req_ready_o is 1 in the same cycle as rsp_done_o, so a request presented in that cycle starts the next script at once.
- Defaults: START_OP=16'hFFFF, ADDR_OP=16'h000E, DATA_OP=16'h4000, WR_OP=16'h0003, RD_OP=16'h0001, PHY_ID=0, PRE_LEN=32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Internal register address |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | Script complete pulse |
| rsp_rdata_o | output | 16 | Read result |
| cmd_valid_o | output | 1 | Frame command pending |
| cmd_write_o | output | 1 | 1 = write frame, 0 = read frame |
| cmd_phy_o | output | 5 | PHY id of the frame |
| cmd_reg_o | output | 5 | MDIO register number |
| cmd_data_o | output | 16 | Frame write data (0 for reads) |
| cmd_pre_o | output | 6 | Preamble length for the frame |
| cmd_done_i | input | 1 | Frame engine finished the current command |
| cmd_rdata_i | input | 16 | Data returned by a read frame |

## Verification
A step counter that is off by one shows at the engine side on the next frame. The bench would see the wrong register or data, or a frame count other than eight or four, before rsp_done_o rises. If the ready gating were wrong, a request made while a script is running would start a second script. That shows up as extra frames within a few cycles of the first script's response. A wrong capture of the read data, or a wrong response timing, shows up in the rsp_rdata_o value or the rsp_done_o cycle checked right after the final frame's done.

// File: rtl/mdio_ind_pkg.sv
package mdio_ind_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned RW = 5;

  // register numbers decoded by the far-end device
  localparam logic [RW-1:0] REG_START  = 5'd29;
  localparam logic [RW-1:0] REG_CTRL_A = 5'd31;
  localparam logic [RW-1:0] REG_ADDR   = 5'd23;
  localparam logic [RW-1:0] REG_WDATA  = 5'd24;
  localparam logic [RW-1:0] REG_CTRL_B = 5'd21;
  localparam logic [RW-1:0] REG_RDATA  = 5'd25;
  localparam logic [RW-1:0] REG_C_CTRL = 5'd13;
  localparam logic [RW-1:0] REG_C_PORT = 5'd14;

  typedef struct packed {
    logic          wr;
    logic [RW-1:0] regn;
    logic [DW-1:0] data;
  } frame_t;
endpackage

// File: rtl/mdio_ind_script_full.sv
module mdio_ind_script_full
  import mdio_ind_pkg::*;
#(
  parameter logic [DW-1:0] START_OP = 16'hFFFF,
  parameter logic [DW-1:0] ADDR_OP  = 16'h000E,
  parameter logic [DW-1:0] WR_OP    = 16'h0003,
  parameter logic [DW-1:0] RD_OP    = 16'h0001
) (
  input  logic [2:0]    step_i,
  input  logic          wr_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output frame_t        frame_o,
  output logic          last_o
);
  always_comb begin
    frame_o = '{wr: 1'b1, regn: REG_START, data: START_OP};
    if (step_i[0]) begin
      unique case (step_i[2:1])
        2'd0: begin frame_o.regn = REG_CTRL_A; frame_o.data = ADDR_OP; end
        2'd1: begin frame_o.regn = REG_ADDR;   frame_o.data = addr_i;  end
        2'd2: begin
          frame_o.regn = wr_i ? REG_WDATA : REG_CTRL_B;
          frame_o.data = wr_i ? wdata_i : RD_OP;
        end
        default: begin
          frame_o.wr   = wr_i;
          frame_o.regn = wr_i ? REG_CTRL_B : REG_RDATA;
          frame_o.data = wr_i ? WR_OP : '0;
        end
      endcase
    end
  end

  assign last_o = (step_i == 3'd7);
endmodule

// File: rtl/mdio_ind_script_compact.sv
module mdio_ind_script_compact
  import mdio_ind_pkg::*;
#(
  parameter logic [DW-1:0] ADDR_OP = 16'h000E,
  parameter logic [DW-1:0] DATA_OP = 16'h4000
) (
  input  logic [1:0]    step_i,
  input  logic          wr_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output frame_t        frame_o,
  output logic          last_o
);
  always_comb begin
    frame_o = '{wr: 1'b1, regn: REG_C_CTRL, data: ADDR_OP};
    unique case (step_i)
      2'd0: ;
      2'd1: begin frame_o.regn = REG_C_PORT; frame_o.data = addr_i; end
      2'd2: frame_o.data = DATA_OP;
      default: begin
        frame_o.wr   = wr_i;
        frame_o.regn = REG_C_PORT;
        frame_o.data = wr_i ? wdata_i : '0;
      end
    endcase
  end

  assign last_o = (step_i == 2'd3);
endmodule

// File: rtl/mdio_ind_ctrl.sv
module mdio_ind_ctrl
  import mdio_ind_pkg::*;
#(
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic [SW-1:0] step_o,
  output logic          wr_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          last_i,
  input  logic          cmd_done_i,
  input  logic [DW-1:0] cmd_rdata_i,
  output logic          cmd_valid_o,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      step_o      <= '0;
      wr_o        <= 1'b0;
      addr_o      <= '0;
      wdata_o     <= '0;
      rsp_done_o  <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q    <= ST_RUN;
          step_o  <= '0;
          wr_o    <= req_write_i;
          addr_o  <= req_addr_i;
          wdata_o <= req_wdata_i;
        end
        default: if (cmd_done_i) begin
          if (last_i) begin
            st_q       <= ST_IDLE;
            rsp_done_o <= 1'b1;
            if (!wr_o) rsp_rdata_o <= cmd_rdata_i;
          end else begin
            step_o <= step_o + 1'b1;
          end
        end
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign cmd_valid_o = (st_q == ST_RUN);
endmodule

// File: rtl/mdio_ind_seq.sv
module mdio_ind_seq
  import mdio_ind_pkg::*;
#(
  parameter bit              COMPACT  = 1'b0,
  parameter int unsigned     PHY_W    = 5,
  parameter int unsigned     PRE_W    = 6,
  parameter logic [PHY_W-1:0] PHY_ID  = '0,
  parameter logic [PRE_W-1:0] PRE_LEN = 6'd32,
  parameter logic [15:0]     START_OP = 16'hFFFF,
  parameter logic [15:0]     ADDR_OP  = 16'h000E,
  parameter logic [15:0]     DATA_OP  = 16'h4000,
  parameter logic [15:0]     WR_OP    = 16'h0003,
  parameter logic [15:0]     RD_OP    = 16'h0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [15:0]      req_addr_i,
  input  logic [15:0]      req_wdata_i,
  output logic             rsp_done_o,
  output logic [15:0]      rsp_rdata_o,
  output logic             cmd_valid_o,
  output logic             cmd_write_o,
  output logic [PHY_W-1:0] cmd_phy_o,
  output logic [4:0]       cmd_reg_o,
  output logic [15:0]      cmd_data_o,
  output logic [PRE_W-1:0] cmd_pre_o,
  input  logic             cmd_done_i,
  input  logic [15:0]      cmd_rdata_i
);
  localparam int unsigned STEPS = COMPACT ? 4 : 8;
  localparam int unsigned SW    = $clog2(STEPS);

  logic [SW-1:0] step;
  logic          wr_q, last;
  logic [DW-1:0] addr_q, wdata_q;
  frame_t        frame;

  mdio_ind_ctrl #(.SW(SW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o),
    .step_o     (step),
    .wr_o       (wr_q),
    .addr_o     (addr_q),
    .wdata_o    (wdata_q),
    .last_i     (last),
    .cmd_done_i (cmd_done_i),
    .cmd_rdata_i(cmd_rdata_i),
    .cmd_valid_o(cmd_valid_o),
    .rsp_done_o (rsp_done_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  generate
    if (COMPACT) begin : g_compact
      mdio_ind_script_compact #(.ADDR_OP(ADDR_OP), .DATA_OP(DATA_OP)) u_script (
        .step_i(step), .wr_i(wr_q), .addr_i(addr_q), .wdata_i(wdata_q),
        .frame_o(frame), .last_o(last)
      );
    end else begin : g_full
      mdio_ind_script_full #(
        .START_OP(START_OP), .ADDR_OP(ADDR_OP), .WR_OP(WR_OP), .RD_OP(RD_OP)
      ) u_script (
        .step_i(step), .wr_i(wr_q), .addr_i(addr_q), .wdata_i(wdata_q),
        .frame_o(frame), .last_o(last)
      );
    end
  endgenerate

  assign cmd_write_o = frame.wr;
  assign cmd_reg_o   = frame.regn;
  assign cmd_data_o  = frame.data;
  assign cmd_phy_o   = PHY_ID;
  assign cmd_pre_o   = PRE_LEN;
endmodule

// File: rtl/mdio_ind_chk.sv
module mdio_ind_chk #(
  parameter int unsigned      PHY_W   = 5,
  parameter int unsigned      PRE_W   = 6,
  parameter logic [PHY_W-1:0] PHY_ID  = '0,
  parameter logic [PRE_W-1:0] PRE_LEN = 6'd32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_done_o,
  input logic             cmd_valid_o,
  input logic             cmd_done_i,
  input logic             cmd_write_o,
  input logic [4:0]       cmd_reg_o,
  input logic [15:0]      cmd_data_o,
  input logic [PHY_W-1:0] cmd_phy_o,
  input logic [PRE_W-1:0] cmd_pre_o
);
  // R2
  accept_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (cmd_valid_o && !req_ready_o));

  // R2
  busy_refuses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !req_ready_o);

  // R6
  frame_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_phy_o == PHY_ID && cmd_pre_o == PRE_LEN));

  // R7
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_done_i) |=>
      (cmd_valid_o && $stable(cmd_write_o) && $stable(cmd_reg_o) && $stable(cmd_data_o)));

  // R8
  rsp_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_done_o) |-> $past(cmd_done_i && cmd_valid_o));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  // R11
  rsp_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> (req_ready_o && !cmd_valid_o));
endmodule

bind mdio_ind_seq mdio_ind_chk #(
  .PHY_W(PHY_W), .PRE_W(PRE_W), .PHY_ID(PHY_ID), .PRE_LEN(PRE_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rsp_done_o (rsp_done_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_done_i (cmd_done_i),
  .cmd_write_o(cmd_write_o),
  .cmd_reg_o  (cmd_reg_o),
  .cmd_data_o (cmd_data_o),
  .cmd_phy_o  (cmd_phy_o),
  .cmd_pre_o  (cmd_pre_o)
);

// File: tb/tb_mdio_ind_seq.sv
module tb_mdio_ind_seq;
  localparam int LAT = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;

  logic        sel = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        done_r = 1'b0;
  logic [15:0] rdata_r = '0;
  logic [15:0] rd_val = '0;

  logic        f_ready, f_rsp, f_cv, f_cw;
  logic [15:0] f_rdata, f_cd;
  logic [4:0]  f_phy, f_reg;
  logic [5:0]  f_pre;
  logic        c_ready, c_rsp, c_cv, c_cw;
  logic [15:0] c_rdata, c_cd;
  logic [4:0]  c_phy, c_reg;
  logic [5:0]  c_pre;

  mdio_ind_seq #(.COMPACT(1'b0)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid && !sel), .req_ready_o(f_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(f_rsp), .rsp_rdata_o(f_rdata),
    .cmd_valid_o(f_cv), .cmd_write_o(f_cw), .cmd_phy_o(f_phy), .cmd_reg_o(f_reg),
    .cmd_data_o(f_cd), .cmd_pre_o(f_pre),
    .cmd_done_i(done_r && !sel), .cmd_rdata_i(rdata_r)
  );

  mdio_ind_seq #(.COMPACT(1'b1)) dut_c (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid && sel), .req_ready_o(c_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(c_rsp), .rsp_rdata_o(c_rdata),
    .cmd_valid_o(c_cv), .cmd_write_o(c_cw), .cmd_phy_o(c_phy), .cmd_reg_o(c_reg),
    .cmd_data_o(c_cd), .cmd_pre_o(c_pre),
    .cmd_done_i(done_r && sel), .cmd_rdata_i(rdata_r)
  );

  wire        m_ready = sel ? c_ready : f_ready;
  wire        m_rsp   = sel ? c_rsp   : f_rsp;
  wire [15:0] m_rdata = sel ? c_rdata : f_rdata;
  wire        m_cv    = sel ? c_cv    : f_cv;
  wire        m_cw    = sel ? c_cw    : f_cw;
  wire [4:0]  m_phy   = sel ? c_phy   : f_phy;
  wire [4:0]  m_reg   = sel ? c_reg   : f_reg;
  wire [15:0] m_cd    = sel ? c_cd    : f_cd;
  wire [5:0]  m_pre   = sel ? c_pre   : f_pre;

  logic        lg_wr [0:31];
  logic [4:0]  lg_reg[0:31];
  logic [15:0] lg_dat[0:31];
  logic [4:0]  lg_phy[0:31];
  logic [5:0]  lg_pre[0:31];
  int          n_frames = 0;

  // frame engine model
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && m_cv) begin
        if (n_frames < 32) begin
          lg_wr[n_frames]  = m_cw;
          lg_reg[n_frames] = m_reg;
          lg_dat[n_frames] = m_cd;
          lg_phy[n_frames] = m_phy;
          lg_pre[n_frames] = m_pre;
        end
        n_frames = n_frames + 1;
        repeat (LAT) @(negedge clk_i);
        done_r  = 1'b1;
        rdata_r = m_cw ? 16'h0000 : rd_val;
        @(negedge clk_i);
        done_r  = 1'b0;
        rdata_r = 16'h0000;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  function automatic void exp_frame(input bit cmp, input bit wr, input int i,
                                    input logic [15:0] a, input logic [15:0] d,
                                    output logic ew, output logic [4:0] er,
                                    output logic [15:0] ed);
    ew = 1'b1;
    if (cmp) begin
      case (i)
        0: begin er = 5'd13; ed = 16'h000E; end
        1: begin er = 5'd14; ed = a; end
        2: begin er = 5'd13; ed = 16'h4000; end
        default: begin er = 5'd14; ew = wr; ed = wr ? d : 16'h0000; end
      endcase
    end else if (i % 2 == 0) begin
      er = 5'd29; ed = 16'hFFFF;
    end else begin
      case (i / 2)
        0: begin er = 5'd31; ed = 16'h000E; end
        1: begin er = 5'd23; ed = a; end
        2: begin er = wr ? 5'd24 : 5'd21; ed = wr ? d : 16'h0001; end
        default: begin ew = wr; er = wr ? 5'd21 : 5'd25; ed = wr ? 16'h0003 : 16'h0000; end
      endcase
    end
  endfunction

  task automatic check_frames(input bit cmp, input bit wr, input logic [15:0] a,
                              input logic [15:0] d, input string req);
    int n = cmp ? 4 : 8;
    logic ew; logic [4:0] er; logic [15:0] ed;
    chk(n_frames == n, req, "frame count", 32'(n_frames), 32'(n));
    for (int i = 0; i < n && i < n_frames; i++) begin
      exp_frame(cmp, wr, i, a, d, ew, er, ed);
      chk(lg_reg[i] == er && lg_dat[i] == ed && lg_wr[i] == ew,
          (!cmp && i % 2 == 0) ? "R5" : req, $sformatf("frame %0d", i),
          {10'd0, lg_wr[i], lg_reg[i], lg_dat[i]}, {10'd0, ew, er, ed});
      chk(lg_phy[i] == 5'd0 && lg_pre[i] == 6'd32, "R6", $sformatf("frame %0d id", i),
          {21'd0, lg_phy[i], lg_pre[i]}, {21'd0, 5'd0, 6'd32});
    end
  endtask

  task automatic wait_rsp(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk_i);
      if (m_rsp) begin seen = 1'b1; break; end
    end
  endtask

  task automatic launch(input bit cmp, input bit wr, input logic [15:0] a,
                        input logic [15:0] d, input logic [15:0] rv);
    @(negedge clk_i);
    sel = cmp; rd_val = rv; n_frames = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk_i);
    chk(m_ready == 1'b0, "R2", "ready after accept", {31'd0, m_ready}, 32'd0);
    req_valid = 1'b0;
  endtask

  // one complete request, scripts R3/R4/R9/R10, response R8
  task automatic t_single(input bit cmp, input bit wr, input logic [15:0] a,
                          input logic [15:0] d, input logic [15:0] rv, input string req);
    bit seen;
    launch(cmp, wr, a, d, rv);
    wait_rsp(seen);
    chk(seen, "R8", "response pulse seen", {31'd0, seen}, 32'd1);
    chk(m_ready == 1'b1, "R11", "ready with response", {31'd0, m_ready}, 32'd1);
    if (!wr) chk(m_rdata == rv, req, "read data", {16'd0, m_rdata}, {16'd0, rv});
    check_frames(cmp, wr, a, d, req);
    @(negedge clk_i);
    chk(m_rsp == 1'b0, "R8", "response one cycle", {31'd0, m_rsp}, 32'd0);
  endtask

  // R2: requests during a script are ignored
  task automatic t_ignore();
    bit seen;
    launch(1'b0, 1'b1, 16'h1234, 16'hBEEF, 16'h0);
    req_valid = 1'b1; req_addr = 16'h5555; req_wdata = 16'hAAAA; req_write = 1'b0;
    repeat (10) @(negedge clk_i);
    req_valid = 1'b0;
    wait_rsp(seen);
    chk(seen, "R2", "response seen", {31'd0, seen}, 32'd1);
    repeat (20) @(negedge clk_i);
    check_frames(1'b0, 1'b1, 16'h1234, 16'hBEEF, "R2");
    chk(m_cv == 1'b0, "R2", "no extra script", {31'd0, m_cv}, 32'd0);
  endtask

  // R11: request in the response cycle is taken at once
  task automatic t_back2back();
    bit seen;
    launch(1'b0, 1'b1, 16'h0F0F, 16'h1111, 16'h0);
    wait_rsp(seen);
    chk(seen && m_ready, "R11", "ready in response cycle", {30'd0, seen, m_ready}, 32'd3);
    n_frames = 0; rd_val = 16'hC3A5;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h00FF;
    @(negedge clk_i);
    chk(m_ready == 1'b0 && m_cv == 1'b1, "R11", "second started",
        {30'd0, m_ready, m_cv}, 32'd1);
    req_valid = 1'b0;
    wait_rsp(seen);
    chk(m_rdata == 16'hC3A5, "R4", "b2b read data", {16'd0, m_rdata}, 32'h0000C3A5);
    check_frames(1'b0, 1'b0, 16'h00FF, 16'h0, "R4");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(f_ready && c_ready, "R1", "ready after reset", {30'd0, f_ready, c_ready}, 32'd3);
    chk(!f_cv && !c_cv, "R1", "cmd idle after reset", {30'd0, f_cv, c_cv}, 32'd0);
    chk(!f_rsp && !c_rsp, "R1", "rsp idle after reset", {30'd0, f_rsp, c_rsp}, 32'd0);
    t_single(1'b0, 1'b1, 16'h1A2B, 16'h3C4D, 16'h0, "R3");
    t_single(1'b0, 1'b0, 16'hFFFF, 16'h0, 16'h8001, "R4");
    t_single(1'b0, 1'b1, 16'h0000, 16'hFFFF, 16'h0, "R3");
    t_single(1'b1, 1'b1, 16'h0123, 16'h4567, 16'h0, "R9");
    t_single(1'b1, 1'b0, 16'hABCD, 16'h0, 16'h5A5A, "R10");
    t_ignore();
    t_back2back();
    summary();
    $finish;
  end
endmodule